// File: doc/BRIEF.md
# Loop-Steered Sine Oscillator

This block is the numerically controlled oscillator at the core of an all-digital phase-locked loop. On every sample strobe it moves a 16-bit phase register forward by a step. The step is the integrated frequency word supplied by the loop, plus a proportional kick: the phase detector's small signed correction multiplied by 256. The kick damps the loop. Between strobes the phase holds.

The top bit of the phase is a square wave at the oscillator frequency, and it is returned to the phase detector as the local signal. The upper twelve phase bits select one point of a full sine cycle. The block emits that point as an unsigned 12-bit converter code: a swing of ±1850 around a mid-scale value of 2048. With a 100 kHz strobe the output frequency is the frequency word × 100 kHz / 65536.

The square wave and the sine code are registered. They change on the same edge as the phase and always describe the current phase value.

Top module: `nco_sine_steer`

## Requirements
- R1: While reset is low and on the first cycle after it, `phase` is 0, `sq_out` is 0 and `sine_code` is 2048.
- R2: A clock edge with `sample_en` high sets `phase` to (phase + fcw + corr×256) mod 65536 on that edge.
- R3: A clock edge with `sample_en` low leaves `phase`, `sq_out` and `sine_code` unchanged.
- R4: `sq_out` always equals bit 15 of `phase`, and it updates on the same edge.
- R5: `sine_code` equals 2048 + round(1850·sin(2π·a/4096)), where a = phase[15:4] and rounding is half away from zero. It updates on the same edge as `phase`.
- R6: `sine_code` always lies within 198 to 3898.
- R7: The phase wraps modulo 65536. With fcw = 65535 and corr = 0, each strobe lowers the phase by exactly 1, and a strobe from 0 gives 65535.
- R8: Starting from phase 0, N strobes with a fixed fcw and corr = 0 produce one rising edge of `sq_out` for each value 32768 + 65536·k that does not exceed N·fcw. For fcw = 1000 and N = 6554 this gives 100 rising edges.
- R9: `corr` is a 2-bit two's-complement value. The codes 00, 01, 11 and 10 mean 0, +1, −1 and −2, so each strobe adds 0, +256, −256 or −512 on top of fcw.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_en | input | 1 | Sample strobe; the phase advances on edges where it is high |
| fcw | input | 16 | Integrated frequency control word |
| corr | input | 2 | Signed phase-detector correction (proportional path) |
| sq_out | output | 1 | Square wave (phase MSB), fed back to the phase detector |
| sine_code | output | 12 | Offset-binary sine sample for the converter |
| phase | output | 16 | Current phase accumulator value |

## Verification
The assertions check four things on every cycle:
- the step arithmetic, including the signed correction and the wrap;
- that the phase holds when no strobe arrives;
- that the square wave and the phase MSB agree;
- that the sine code stays inside its amplitude band.

Only the bench scenarios can show two further properties. The first is that each code is the correctly rounded sine of its address: a sweep visits all 4096 table addresses and compares every code with a value computed from a real sine. The second is that the number of square-wave periods over a long run matches the frequency-word formula.

// File: rtl/nco_pkg.sv
package nco_pkg;

    localparam int NCO_PHASE_W    = 16;
    localparam int NCO_LUT_AW     = 12;
    localparam int NCO_DAC_W      = 12;
    localparam int NCO_CORR_W     = 2;
    localparam int NCO_CORR_SHIFT = 8;
    localparam int NCO_AMPLITUDE  = 1850;

    // Quadrant of the sine cycle, taken from the two top address bits.
    typedef enum logic [1:0] {
        QD_RISE = 2'b00,
        QD_FALL = 2'b01,
        QD_DIP  = 2'b10,
        QD_BACK = 2'b11
    } quadrant_e;

    // amp * sin(idx/qlen * pi/2), rounded to the nearest integer; idx in 0..qlen.
    function automatic int quarter_sine(input int idx, input int qlen, input int amp);
        real x;
        real term;
        real sum;
        x    = (3.14159265358979323846 / 2.0) * real'(idx) / real'(qlen);
        term = x;
        sum  = x;
        for (int k = 1; k < 11; k++) begin
            term = -term * x * x / real'((2 * k) * (2 * k + 1));
            sum  = sum + term;
        end
        return $rtoi(real'(amp) * sum + 0.5);
    endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
    parameter int PHASE_W    = 16,
    parameter int CORR_W     = 2,
    parameter int CORR_SHIFT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_en,
    input  logic [PHASE_W-1:0] fcw,
    input  logic [CORR_W-1:0]  corr,
    output logic [PHASE_W-1:0] phase_next,
    output logic [PHASE_W-1:0] phase_cur
);

    localparam int EXT_W = PHASE_W - CORR_W;

    typedef struct packed {
        logic [PHASE_W-1:0] acc;
    } acc_state_t;

    acc_state_t         st_d, st_q;
    logic [PHASE_W-1:0] corr_ext;
    logic [PHASE_W-1:0] step;

    always_comb begin
        st_d     = st_q;
        corr_ext = {{EXT_W{corr[CORR_W-1]}}, corr};
        step     = fcw + (corr_ext << CORR_SHIFT);
        if (step_en) begin
            st_d.acc = st_q.acc + step;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_next = st_d.acc;
    assign phase_cur  = st_q.acc;

    // R2 R7 R9
    step_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> phase_cur == PHASE_W'($past(phase_cur) + $past(fcw)
                     + ({{EXT_W{$past(corr[CORR_W-1])}}, $past(corr)} << CORR_SHIFT)));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(phase_cur));

endmodule

// File: rtl/nco_sine_out.sv
module nco_sine_out
    import nco_pkg::*;
#(
    parameter int PHASE_W   = 16,
    parameter int LUT_AW    = 12,
    parameter int DAC_W     = 12,
    parameter int AMPLITUDE = 1850
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [PHASE_W-1:0] phase_next,
    output logic               sq_q_o,
    output logic [DAC_W-1:0]   code_q_o
);

    localparam int QAW    = LUT_AW - 2;
    localparam int QLEN   = 1 << QAW;
    localparam int MAG_W  = DAC_W - 1;
    localparam int MID    = 1 << (DAC_W - 1);
    localparam int IDX_W  = QAW + 1;

    typedef struct packed {
        logic             sq;
        logic [DAC_W-1:0] code;
    } out_state_t;

    // Quarter-wave table, entries 0..QLEN inclusive, built at elaboration.
    logic [MAG_W-1:0] qtab [QLEN+1];
    for (genvar i = 0; i <= QLEN; i++) begin : g_qtab
        localparam int ENTRY = quarter_sine(i, QLEN, AMPLITUDE);
        assign qtab[i] = MAG_W'(ENTRY);
    end

    out_state_t        st_d, st_q;
    logic [LUT_AW-1:0] addr;
    quadrant_e         quad;
    logic [QAW-1:0]    fine;
    logic [IDX_W-1:0]  idx;
    logic [MAG_W-1:0]  mag;

    always_comb begin
        st_d = st_q;
        addr = phase_next[PHASE_W-1 -: LUT_AW];
        quad = quadrant_e'(addr[LUT_AW-1 -: 2]);
        fine = addr[QAW-1:0];
        if (quad == QD_FALL || quad == QD_BACK) begin
            idx = IDX_W'(QLEN) - {1'b0, fine};
        end else begin
            idx = {1'b0, fine};
        end
        mag = qtab[idx];
        if (load) begin
            st_d.sq = phase_next[PHASE_W-1];
            if (quad == QD_DIP || quad == QD_BACK) begin
                st_d.code = DAC_W'(MID) - {1'b0, mag};
            end else begin
                st_d.code = DAC_W'(MID) + {1'b0, mag};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sq   <= 1'b0;
            st_q.code <= DAC_W'(MID);
        end else begin
            st_q <= st_d;
        end
    end

    assign sq_q_o   = st_q.sq;
    assign code_q_o = st_q.code;

    // R6
    code_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q_o >= DAC_W'(MID - AMPLITUDE)) && (code_q_o <= DAC_W'(MID + AMPLITUDE)));

    // R3
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(code_q_o) && $stable(sq_q_o));

endmodule

// File: rtl/nco_sine_steer.sv
module nco_sine_steer
    import nco_pkg::*;
#(
    parameter int PHASE_W    = NCO_PHASE_W,
    parameter int LUT_AW     = NCO_LUT_AW,
    parameter int DAC_W      = NCO_DAC_W,
    parameter int CORR_W     = NCO_CORR_W,
    parameter int CORR_SHIFT = NCO_CORR_SHIFT,
    parameter int AMPLITUDE  = NCO_AMPLITUDE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sample_en,
    input  logic [PHASE_W-1:0] fcw,
    input  logic [CORR_W-1:0]  corr,
    output logic               sq_out,
    output logic [DAC_W-1:0]   sine_code,
    output logic [PHASE_W-1:0] phase
);

    logic [PHASE_W-1:0] phase_d;
    logic [PHASE_W-1:0] phase_q;

    nco_phase_acc #(
        .PHASE_W    (PHASE_W),
        .CORR_W     (CORR_W),
        .CORR_SHIFT (CORR_SHIFT)
    ) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_en    (sample_en),
        .fcw        (fcw),
        .corr       (corr),
        .phase_next (phase_d),
        .phase_cur  (phase_q)
    );

    nco_sine_out #(
        .PHASE_W   (PHASE_W),
        .LUT_AW    (LUT_AW),
        .DAC_W     (DAC_W),
        .AMPLITUDE (AMPLITUDE)
    ) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (sample_en),
        .phase_next (phase_d),
        .sq_q_o     (sq_out),
        .code_q_o   (sine_code)
    );

    assign phase = phase_q;

    // R4
    sq_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sq_out == phase[PHASE_W-1]);

endmodule

// File: tb/nco_sine_steer_tb.sv
module nco_sine_steer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_en = 1'b0;
    logic [15:0] fcw = '0;
    logic [1:0]  corr = '0;
    logic        sq_out;
    logic [11:0] sine_code;
    logic [15:0] phase;

    int checks = 0;
    int errors = 0;
    int model  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    nco_sine_steer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .fcw       (fcw),
        .corr      (corr),
        .sq_out    (sq_out),
        .sine_code (sine_code),
        .phase     (phase)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_code(input int ph);
        real s;
        int  a;
        a = (ph >> 4) & 12'hFFF;
        s = 1850.0 * $sin(2.0 * 3.14159265358979323846 * real'(a) / 4096.0);
        if (s >= 0.0) return 2048 + $rtoi(s + 0.5);
        return 2048 - $rtoi(-s + 0.5);
    endfunction

    function automatic int corr_val(input logic [1:0] c);
        case (c)
            2'b01:   return 1;
            2'b11:   return -1;
            2'b10:   return -2;
            default: return 0;
        endcase
    endfunction

    // One cycle: drive at negedge, let the edge pass, compare at the next negedge.
    task automatic step(input bit en, input int f, input logic [1:0] c, input bit full);
        int prev_ph;
        int prev_code;
        int prev_sq;
        prev_ph = phase; prev_code = sine_code; prev_sq = sq_out;
        sample_en = en; fcw = 16'(f); corr = c;
        @(posedge clk);
        @(negedge clk);
        if (en) model = (model + f + corr_val(c) * 256) & 16'hFFFF;
        if (!en) begin
            chk("R3 phase hold", phase, prev_ph);
            chk("R3 code hold", sine_code, prev_code);
            chk("R3 sq hold", sq_out, prev_sq);
        end else begin
            chk("R2 phase step", phase, model);
        end
        if (full) begin
            chk("R5 sine code", sine_code, exp_code(model));
            chk("R4 sq bit", sq_out, (model >> 15) & 1);
        end
    endtask

    task automatic do_reset();
        sample_en = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R1 phase in reset", phase, 0);
        rst_n = 1'b1;
        @(negedge clk);
        model = 0;
        chk("R1 phase", phase, 0);
        chk("R1 sq", sq_out, 0);
        chk("R1 code", sine_code, 2048);
    endtask

    initial begin
        @(negedge clk);
        do_reset();

        // Sweep every table address; every third cycle has no strobe.
        for (int i = 0; i < 4096; i++) begin
            step(1'b1, 16, 2'b00, 1'b1);
            if (i % 3 == 2) step(1'b0, 16, 2'b00, 1'b0);
        end
        chk("R5 full cycle back to zero", phase, 0);

        // Signed correction codes on top of a nominal word.
        for (int i = 0; i < 3000; i++) begin
            step(1'b1, 655 + (i % 7) * 97, 2'(i % 4), 1'b1);
        end

        // Extreme corrections and modulo wrap.
        do_reset();
        step(1'b1, 16'hFFFF, 2'b00, 1'b1);
        chk("R7 wrap below zero", phase, 65535);
        for (int i = 0; i < 20; i++) step(1'b1, 16'hFFFF, 2'b00, 1'b1);
        chk("R7 minus one per strobe", phase, 65535 - 20);
        step(1'b1, 100, 2'b10, 1'b1);
        chk("R9 code 10 is -2", phase, (65535 - 20 + 100 - 512) & 16'hFFFF);
        step(1'b1, 100, 2'b01, 1'b1);
        chk("R9 code 01 is +1", phase, (65535 - 20 + 200 - 256) & 16'hFFFF);

        // Period count against the frequency formula.
        do_reset();
        begin
            int rises;
            int last;
            int expect_r;
            rises = 0;
            last  = sq_out;
            for (int i = 0; i < 6554; i++) begin
                step(1'b1, 1000, 2'b00, 1'b0);
                if (sq_out && !last) rises++;
                last = sq_out;
            end
            expect_r = 0;
            for (int k = 0; 32768 + 65536 * k <= 6554 * 1000; k++) expect_r++;
            chk("R8 rising edge count", rises, expect_r);
            chk("R8 count equals 100", rises, 100);
        end

        done = 1;
    end

    initial begin
        for (int n = 0; n < 150000 && !done; n++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", 0, 1);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule